// File: doc/BRIEF.md
# Serial Multiplying-DAC Control Front End

This block is the digital side of a serial-input, current-output DAC. A host sends 16-bit frames over three wires: a serial clock, an active-low frame select and serial data. The block decodes a 4-bit command at the top of each frame and keeps a DAC code register of `CODE_W` bits (8, 10 or 12). That register drives the converter's switch bus. A serial data output lets several parts share one data line in a chain, and it also returns the stored code after a readback request.

All pins are sampled by a system clock that runs at least four times faster than the serial clock. Each pin passes through a two-flop synchroniser, and serial-clock and frame-select edges are found from the synchronised samples. Commands can change how the interface itself behaves while it runs. One command moves the capture edge from falling to rising. Another turns chained shifting off, which puts the interface into counted stand-alone framing. Both settings hold until reset.

The block has no valid/ready handshake. Frame timing is set by the host through the serial pins, and the block cannot push back on it. `dac_code` is a plain level that changes only when a frame executes.

Top module: `sdac_ctrl`

## Requirements
- R1: A frame is shifted in MSB first. Frame bits 15..12 hold the command and bits 11..0 hold the data field. Command 0001 loads the top `CODE_W` bits of the data field into `dac_code` and discards the lower `12-CODE_W` bits.
- R2: After reset, `dac_code` is 0 and `sdo` is 0. Capture is on falling serial-clock edges and chained mode is on.
- R3: Command 1011 sets `dac_code` to zero. Command 1100 sets it to midscale, which is only the most significant bit set.
- R4: Commands 0000, 0011 through 1000 and 1101 through 1111 change nothing.
- R5: Serial-clock activity while `sync_n` is high does not shift data and does not move `sdo`.
- R6: In chained mode, every active edge while `sync_n` is low shifts a bit in. When `sync_n` rises, the last 16 bits held in the register are executed as the frame.
- R7: `sdo` shows the register's MSB from the falling edge of `sync_n` onward. It then updates on each serial-clock edge opposite the capture edge, so the bits in the register leave MSB first.
- R8: In stand-alone mode, a falling edge of `sync_n` clears the bit count. The frame executes on the 16th active edge, without waiting for `sync_n` to rise. Later edges are ignored until the next falling edge of `sync_n`.
- R9: In stand-alone mode, if `sync_n` rises before 16 edges have been counted, the frame is abandoned and nothing executes.
- R10: Command 1010 moves capture to rising serial-clock edges until reset.
- R11: Command 0010 loads the word {0000, code left-aligned in 12 bits, zeros below} into the shift register. That word appears on `sdo` during the next frame.
- R12: Command 1001 turns chained mode off until reset. A later frame of more than 16 clocks therefore executes its first 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| sclk | input | 1 | Serial clock from the host |
| sync_n | input | 1 | Active-low frame select |
| sdin | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, for the chain or readback |
| dac_code | output | CODE_W | Code driving the converter |

## Verification
Every pin change reaches the edge detectors two system clocks later. The register it affects updates on the third clock. `sdo` therefore settles three clocks after a launch edge or a falling edge of `sync_n`, and `dac_code` settles three clocks after the 16th capture edge or the rise of `sync_n`. The bench holds each serial-clock phase for eight system clocks and reads `sdo` at the end of the phase, just before the capture edge. It queues the expected code eight clocks after the executing event, and a monitor compares that entry on the next falling clock edge. A second instance with an 8-bit code runs beside the 12-bit one to cover the discarded low bits and the left-aligned readback.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int FRAME_W = 16;
  localparam int CMD_W   = 4;
  localparam int FIELD_W = FRAME_W - CMD_W;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP     = 4'b0000,
    CMD_LOAD    = 4'b0001,
    CMD_RDBK    = 4'b0010,
    CMD_NOCHAIN = 4'b1001,
    CMD_RISE    = 4'b1010,
    CMD_ZERO    = 4'b1011,
    CMD_MID     = 4'b1100
  } sdac_cmd_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [2:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= {3{RST_VAL[i]}};
      else        sh_q <= {sh_q[1:0], pin_i[i]};
    end
    assign lvl_o[i]  = sh_q[1];
    assign rise_o[i] = sh_q[1] & ~sh_q[2];
    assign fall_o[i] = ~sh_q[1] & sh_q[2];
  end
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift
  import sdac_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_i,
  input  logic               lnch_i,
  input  logic               sel_i,
  input  logic               sel_fall_i,
  input  logic               sel_rise_i,
  input  logic               din_i,
  input  logic               chain_i,
  input  logic               ld_i,
  input  logic [FRAME_W-1:0] ld_word_i,
  output logic               frame_done_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               sdo_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] sreg_q;
  logic [FRAME_W-1:0] next_word;
  logic [CNT_W-1:0]   cnt_q;
  logic               sdo_q;
  logic               accept, sa_done, ch_done;

  // sel_i is high while the frame select pin is low
  assign accept    = sel_i & cap_i & (chain_i | (cnt_q < CNT_FULL));
  assign next_word = {sreg_q[FRAME_W-2:0], din_i};
  assign sa_done   = ~chain_i & accept & (cnt_q == CNT_LAST);
  assign ch_done   = chain_i & sel_rise_i;

  assign frame_done_o = sa_done | ch_done;
  assign frame_o      = sa_done ? next_word : sreg_q;
  assign sdo_o        = sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sreg_q <= '0;
    else if (ld_i)   sreg_q <= ld_word_i;
    else if (accept) sreg_q <= next_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (sel_fall_i)         cnt_q <= '0;
    else if (accept && !chain_i) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                sdo_q <= 1'b0;
    else if (sel_fall_i)       sdo_q <= sreg_q[FRAME_W-1];
    else if (sel_i && lnch_i)  sdo_q <= sreg_q[FRAME_W-1];
  end

  assert_cnt_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
  assert_sa_inframe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done_o && !chain_i) |-> sel_i);
  assert_sdo_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> $stable(sdo_q));
  assert_no_shift_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_i && !ld_i) |=> $stable(sreg_q));
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
  import sdac_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_done_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [CODE_W-1:0]  code_o,
  output logic               chain_o,
  output logic               rise_o,
  output logic               ld_o,
  output logic [FRAME_W-1:0] ld_word_o
);
  localparam int PAD_W = FIELD_W - CODE_W;
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  sdac_cmd_e         cmd;
  logic [CODE_W-1:0] data;
  logic [CODE_W-1:0] code_q;
  logic              chain_q, rise_q;

  assign cmd  = sdac_cmd_e'(frame_i[FRAME_W-1 -: CMD_W]);
  assign data = frame_i[FIELD_W-1 -: CODE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      chain_q <= 1'b1;
      rise_q  <= 1'b0;
    end else if (frame_done_i) begin
      case (cmd)
        CMD_LOAD:    code_q  <= data;
        CMD_ZERO:    code_q  <= '0;
        CMD_MID:     code_q  <= MID;
        CMD_NOCHAIN: chain_q <= 1'b0;
        CMD_RISE:    rise_q  <= 1'b1;
        default:     ;
      endcase
    end
  end

  assign ld_o = frame_done_i && (cmd == CMD_RDBK);

  if (PAD_W > 0) begin : g_pad
    assign ld_word_o = {{CMD_W{1'b0}}, code_q, {PAD_W{1'b0}}};
  end else begin : g_nopad
    assign ld_word_o = {{CMD_W{1'b0}}, code_q};
  end

  assign code_o  = code_q;
  assign chain_o = chain_q;
  assign rise_o  = rise_q;

  assert_code_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done_i |=> $stable(code_q));
  assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done_i && frame_i[FRAME_W-1 -: CMD_W] == 4'b0001) |=> code_q == $past(data));
  assert_chain_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_q |=> !chain_q);
  assert_rise_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |=> rise_q);
endmodule

// File: rtl/sdac_ctrl.sv
module sdac_ctrl
  import sdac_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sync_n,
  input  logic              sdin,
  output logic              sdo,
  output logic [CODE_W-1:0] dac_code
);
  // bit 0 serial clock, bit 1 frame select, bit 2 data
  logic [2:0] lvl, rise, fall;
  logic       cap, lnch, chain, rise_mode;
  logic       frame_done, ld;
  logic [FRAME_W-1:0] frame, ld_word;
  logic       unused_bits;

  sdac_sync #(.W(3), .RST_VAL(3'b011)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i({sdin, sync_n, sclk}),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  assign unused_bits = ^{lvl[0], rise[2], fall[2]};
  assign cap  = rise_mode ? rise[0] : fall[0];
  assign lnch = rise_mode ? fall[0] : rise[0];

  sdac_shift u_shift (
    .clk(clk), .rst_n(rst_n), .cap_i(cap), .lnch_i(lnch),
    .sel_i(~lvl[1]), .sel_fall_i(fall[1]), .sel_rise_i(rise[1]),
    .din_i(lvl[2]), .chain_i(chain), .ld_i(ld), .ld_word_i(ld_word),
    .frame_done_o(frame_done), .frame_o(frame), .sdo_o(sdo)
  );

  sdac_regs #(.CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .frame_done_i(frame_done), .frame_i(frame),
    .code_o(dac_code), .chain_o(chain), .rise_o(rise_mode),
    .ld_o(ld), .ld_word_o(ld_word)
  );

  assert_exec_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (cap || rise[1]));
endmodule

// File: tb/sdac_ctrl_tb.sv
module sdac_ctrl_tb;
  logic clk = 0, rst_n = 0, sclk = 1, sync_n = 1, sdin = 0;
  logic sdo12, sdo8;
  logic [11:0] code12;
  logic [7:0]  code8;
  int checks = 0, fails = 0;

  logic [11:0] m_code12;
  logic [7:0]  m_code8;
  logic [15:0] m_sreg12, m_sreg8;
  logic        m_chain, m_rise;

  logic [11:0] q12[$];
  logic [7:0]  q8[$];
  string       qt[$];

  always #5 clk = ~clk;

  sdac_ctrl #(.CODE_W(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .sdin(sdin),
    .sdo(sdo12), .dac_code(code12));
  sdac_ctrl #(.CODE_W(8)) u_dut8 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .sdin(sdin),
    .sdo(sdo8), .dac_code(code8));

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected codes and compares
  initial begin
    forever begin
      wait (q12.size() != 0);
      @(negedge clk);
      begin
        logic [11:0] e12; logic [7:0] e8; string t;
        e12 = q12.pop_front(); e8 = q8.pop_front(); t = qt.pop_front();
        chk(code12 === e12, t, {4'h0, code12}, {4'h0, e12});
        chk(code8 === e8, t, {8'h0, code8}, {8'h0, e8});
      end
    end
  end

  task automatic expect_codes(input string tag);
    q12.push_back(m_code12); q8.push_back(m_code8); qt.push_back(tag);
    wait (q12.size() == 0);
    @(negedge clk);
  endtask

  task automatic exec(input logic [15:0] w);
    case (w[15:12])
      4'b0001: begin m_code12 = w[11:0]; m_code8 = w[11:4]; end
      4'b0010: begin m_sreg12 = {4'h0, m_code12}; m_sreg8 = {4'h0, m_code8, 4'h0}; end
      4'b1001: m_chain = 1'b0;
      4'b1010: m_rise = 1'b1;
      4'b1011: begin m_code12 = '0; m_code8 = '0; end
      4'b1100: begin m_code12 = 12'h800; m_code8 = 8'h80; end
      default: ;
    endcase
  endtask

  task automatic frame(input logic [63:0] bits, input int n, input string stag, input string ctag);
    int cnt;
    logic capl, b;
    cnt = 0;
    capl = m_rise;
    sclk = ~capl;
    repeat (8) @(negedge clk);
    sync_n = 0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      b = bits[n-1-i];
      sdin = b;
      repeat (8) @(negedge clk);
      if (m_chain || cnt < 16) begin
        chk(sdo12 === m_sreg12[15], stag, {15'h0, sdo12}, {15'h0, m_sreg12[15]});
        chk(sdo8 === m_sreg8[15], stag, {15'h0, sdo8}, {15'h0, m_sreg8[15]});
      end
      sclk = capl;
      if (m_chain || cnt < 16) begin
        m_sreg12 = {m_sreg12[14:0], b};
        m_sreg8  = {m_sreg8[14:0], b};
        cnt++;
      end
      repeat (8) @(negedge clk);
      if (!m_chain && cnt == 16) begin
        exec(m_sreg12);
        expect_codes(ctag);
        cnt = 17;
      end
      sclk = ~capl;
    end
    repeat (8) @(negedge clk);
    sync_n = 1;
    if (m_chain) exec(m_sreg12);
    repeat (8) @(negedge clk);
    expect_codes(ctag);
  endtask

  task automatic idle_toggle();
    sdin = 1;
    for (int k = 0; k < 12; k++) begin
      sclk = ~sclk;
      repeat (8) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    m_code12 = '0; m_code8 = '0; m_sreg12 = '0; m_sreg8 = '0;
    m_chain = 1'b1; m_rise = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R2 reset state
    chk(code12 === 12'h000, "R2", {4'h0, code12}, 16'h0);
    chk(code8 === 8'h00, "R2", {8'h0, code8}, 16'h0);
    chk(sdo12 === 1'b0, "R2", {15'h0, sdo12}, 16'h0);
    // R1 load, both widths; R6 execution at frame-select rise
    frame(64'h1ABC, 16, "R7", "R1");
    frame(64'h1123_1456, 32, "R7", "R6");
    // R11 readback in chained mode
    frame(64'h2000, 16, "R7", "R11");
    frame(64'h0000, 16, "R11", "R4");
    // R5 clock activity with frame select high
    idle_toggle();
    frame(64'h1555, 16, "R5", "R5");
    // R3 clears
    frame(64'hC000, 16, "R7", "R3");
    frame(64'hB000, 16, "R7", "R3");
    frame(64'h1555, 16, "R7", "R1");
    // R4 reserved codes
    frame(64'h3FFF, 16, "R7", "R4");
    frame(64'h8FFF, 16, "R7", "R4");
    frame(64'hDFFF, 16, "R7", "R4");
    frame(64'hFFFF, 16, "R7", "R4");
    // R12 leave chained mode
    frame(64'h9000, 16, "R7", "R12");
    // R8 stand-alone: executes on 16th edge, extra edges ignored
    frame({44'h0, 16'h1321, 4'hF}, 20, "R8", "R8");
    // R9 abort after 10 edges
    frame(64'h07F, 10, "R8", "R9");
    frame(64'h1077, 16, "R7", "R9");
    // R10 rising capture
    frame(64'hA000, 16, "R7", "R10");
    frame(64'h1EEE, 16, "R10", "R10");
    // R11 readback in stand-alone, rising capture
    frame(64'h2000, 16, "R10", "R11");
    frame(64'h0000, 16, "R11", "R11");
    // R12 long frame executes first 16 bits
    frame({44'h0, 16'h1001, 4'h0}, 20, "R12", "R12");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule